// File: doc/BRIEF.md
# Bus-master IDE channel control registers

This block is the register set that a host sees for one bus-master IDE channel. It holds three registers. The command byte carries a start flag and a transfer direction. The status byte carries an active flag, an error flag and an interrupt flag. A 32-bit base register holds the address of the descriptor table. The host reaches them through a byte-addressed port that can read or write one byte, a halfword or a word in a single access.

A separate DMA engine walks the descriptor table. This block starts that engine with a one-cycle pulse and hands it the direction and a descriptor pointer. The pointer is loaded from the base register whenever the start flag rises. The engine reports back when a transfer completes or ends early. The drive interrupt line is passed straight through to the host. A rising edge on that line also sets the interrupt flag in the status register.

The register offsets are fixed: 0 is the command byte, 2 is the status byte, and 4 to 7 are the base register, least significant byte at offset 4. An access size code of 0 means byte, 1 means halfword and 2 means word. Read data is right-aligned. A read of any other offset returns zero.

Top module: `bmide_regs`

## Requirements
- R1: A write to offset 0 keeps only bit 0 (start) and bit 3 (direction) of the written byte. Every other bit of the command register reads back as 0.
- R2: A command write that changes start from 0 to 1 while status bit 0 (active) is 0 does three things. It sets active. It gives eng_start a one-cycle pulse in the cycle after the write. It loads eng_ptr with the base register in that same cycle.
- R3: A command write whose start bit equals the stored start bit causes no pulse and no pointer reload. A 0-to-1 change while active is already 1 reloads eng_ptr but gives no pulse.
- R4: A command write that clears start leaves active set. Active stays set until eng_done or eng_abort is seen, and eng_done clears it in the next cycle.
- R5: A write at offsets 4 to 7 replaces only the byte lanes it covers, starting at lane offset-4. Lanes beyond byte 3 are dropped. Bits 1:0 of the base register always read as 0. A read returns the register shifted down by (offset-4) bytes and masked to the access size.
- R6: host_irq equals drv_irq in the same cycle. A rising edge of drv_irq sets status bit 2 (interrupt) in the next cycle. A falling edge, or drv_irq simply staying high, does not change that bit.
- R7: A write to offset 2 clears bit 1 (error) and/or bit 2 (interrupt) wherever the written bit is 1. It never changes bit 0 (active).
- R8: eng_abort sets status bit 1 (error) and clears active in the next cycle.
- R9: eng_dir equals command bit 3. A value of 1 means memory is written from the device.
- R10: Reset clears the command, status and base registers and eng_ptr. It also drops any active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the access |
| reg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Write data, right-aligned |
| reg_rdata | output | 32 | Read data for reg_addr/reg_size, combinational |
| eng_start | output | 1 | One-cycle start pulse to the DMA engine |
| eng_dir | output | 1 | Direction, 1 means memory is written from the device |
| eng_ptr | output | 32 | Descriptor pointer loaded at start |
| eng_done | input | 1 | Transfer completed, clears active |
| eng_abort | input | 1 | Transfer ended early, sets error |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |

## Verification
Register reads and host_irq are combinational, so they are due in the same cycle as the access or the drive level. Status changes, eng_start and eng_ptr are due one clock after the write or engine event that causes them. A behavioural reference model advances at each rising edge from the inputs that were held across that edge. One time unit later the model's outputs are compared with the design's outputs, and directed checks sample at the following falling edge. Because of this, every registered result is taken exactly one edge after its cause, and every combinational result is taken while its inputs are stable.

// File: rtl/bmide_regs.sv
module bmide_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [1:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        eng_start,
  output logic        eng_dir,
  output logic [31:0] eng_ptr,
  input  logic        eng_done,
  input  logic        eng_abort,
  input  logic        drv_irq,
  output logic        host_irq
);
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;

  logic        start_q, dir_q;
  logic        act_q, err_q, irq_q;
  logic        drv_q, start_p_q;
  logic [31:0] base_q, ptr_q, base_new, base_rd, shifted;
  logic [1:0]  lane_off;
  logic        wr_cmd, wr_stat, wr_base, start_chg, fire;

  assign lane_off  = reg_addr[1:0];
  assign wr_cmd    = reg_we && (reg_addr == OFS_CMD);
  assign wr_stat   = reg_we && (reg_addr == OFS_STAT);
  assign wr_base   = reg_we && reg_addr[2];
  assign start_chg = wr_cmd && (reg_wdata[0] != start_q);
  assign fire      = start_chg && reg_wdata[0] && !act_q;

  always_comb begin
    int nb;
    nb = (reg_size == 2'd0) ? 1 : (reg_size == 2'd1) ? 2 : 4;
    shifted  = reg_wdata << {lane_off, 3'b000};
    base_new = base_q;
    for (int i = 0; i < 4; i++) begin
      if (i >= int'(lane_off) && i < int'(lane_off) + nb)
        base_new[i*8 +: 8] = shifted[i*8 +: 8];
    end
    base_new[1:0] = 2'b00;
  end

  always_comb begin
    base_rd = base_q >> {lane_off, 3'b000};
    case (reg_size)
      2'd0:    base_rd = base_rd & 32'h0000_00ff;
      2'd1:    base_rd = base_rd & 32'h0000_ffff;
      default: base_rd = base_rd;
    endcase
    if (reg_addr[2])                 reg_rdata = base_rd;
    else if (reg_addr == OFS_CMD)    reg_rdata = {28'd0, dir_q, 2'b00, start_q};
    else if (reg_addr == OFS_STAT)   reg_rdata = {29'd0, irq_q, err_q, act_q};
    else                             reg_rdata = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      dir_q     <= 1'b0;
      act_q     <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
      drv_q     <= 1'b0;
      start_p_q <= 1'b0;
      base_q    <= 32'd0;
      ptr_q     <= 32'd0;
    end else begin
      drv_q     <= drv_irq;
      start_p_q <= fire;
      if (wr_cmd) begin
        start_q <= reg_wdata[0];
        dir_q   <= reg_wdata[3];
      end
      if (start_chg && reg_wdata[0]) ptr_q <= base_q;
      if (wr_base) base_q <= base_new;
      act_q <= (act_q && !eng_done && !eng_abort) || fire;
      err_q <= (err_q && !(wr_stat && reg_wdata[1])) || eng_abort;
      irq_q <= (irq_q && !(wr_stat && reg_wdata[2])) || (drv_irq && !drv_q);
    end
  end

  assign eng_start = start_p_q;
  assign eng_dir   = dir_q;
  assign eng_ptr   = ptr_q;
  assign host_irq  = drv_irq;
endmodule

module bmide_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [1:0]  reg_size,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        start_q,
  input logic        act_q,
  input logic        err_q,
  input logic        irq_q,
  input logic        eng_start,
  input logic        eng_done,
  input logic        eng_abort,
  input logic        drv_irq
);
  a_r2_pulse_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> act_q);
  a_r3_same_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[0] == start_q) |=> !eng_start);
  a_r4_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !eng_done && !eng_abort) |=> act_q);
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4 && reg_size == 2'd2) |-> (reg_rdata[1:0] == 2'b00));
  a_r6_irq_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> irq_q);
  a_r7_active_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && !act_q) |=> !act_q);
  a_r8_abort_error: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_abort && !reg_we) |=> (err_q && !act_q));
endmodule

bind bmide_regs bmide_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .start_q(start_q), .act_q(act_q), .err_q(err_q), .irq_q(irq_q),
  .eng_start(eng_start), .eng_done(eng_done), .eng_abort(eng_abort),
  .drv_irq(drv_irq)
);

// File: tb/sim_bmide_regs.sv
`timescale 1ns/1ps
module sim_bmide_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [1:0]  reg_size = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_dir;
  logic [31:0] eng_ptr;
  logic        eng_done = 1'b0, eng_abort = 1'b0, drv_irq = 1'b0;
  logic        host_irq;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bmide_regs u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_dir(eng_dir), .eng_ptr(eng_ptr),
    .eng_done(eng_done), .eng_abort(eng_abort), .drv_irq(drv_irq),
    .host_irq(host_irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit        m_start, m_dir, m_act, m_err, m_irq, m_drvq, m_pulse;
  bit [31:0] m_base, m_ptr;

  function automatic bit [31:0] m_read(input bit [2:0] a, input bit [1:0] s);
    bit [31:0] v;
    if (a >= 3'd4) begin
      v = m_base;
      for (int k = 0; k < int'(a) - 4; k++) v = v / 256;
      if (s == 0) v = v % 256;
      else if (s == 1) v = v % 65536;
      return v;
    end
    if (a == 3'd0) return m_start + (m_dir ? 8 : 0);
    if (a == 3'd2) return m_act + (m_err ? 2 : 0) + (m_irq ? 4 : 0);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_start, m_dir, m_act, m_err, m_irq, m_drvq, m_pulse} = '0;
      m_base = 0; m_ptr = 0;
    end else begin
      bit fire_n, act_n, err_n, irq_n;
      bit [31:0] nb;
      fire_n = 0;
      nb = m_base;
      if (reg_we && reg_addr == 0 && reg_wdata[0] != m_start && reg_wdata[0]) begin
        m_ptr = m_base;
        fire_n = !m_act;
      end
      act_n = (m_act && !eng_done && !eng_abort) || fire_n;
      err_n = m_err && !(reg_we && reg_addr == 2 && reg_wdata[1]);
      if (eng_abort) err_n = 1;
      irq_n = m_irq && !(reg_we && reg_addr == 2 && reg_wdata[2]);
      if (drv_irq && !m_drvq) irq_n = 1;
      if (reg_we && reg_addr >= 4) begin
        int n;
        n = (reg_size == 0) ? 1 : (reg_size == 1) ? 2 : 4;
        for (int j = 0; j < n; j++)
          if (int'(reg_addr) - 4 + j < 4)
            nb[(int'(reg_addr) - 4 + j) * 8 +: 8] = reg_wdata[j*8 +: 8];
        nb[1:0] = 0;
      end
      if (reg_we && reg_addr == 0) begin
        m_start = reg_wdata[0];
        m_dir = reg_wdata[3];
      end
      m_base = nb; m_act = act_n; m_err = err_n; m_irq = irq_n;
      m_drvq = drv_irq; m_pulse = fire_n;
    end
    #1;
    if (rst_n && !finished) begin
      check(eng_start, m_pulse, "R2/R3 model eng_start");
      check(eng_ptr, m_ptr, "R2/R3 model eng_ptr");
      check(eng_dir, m_dir, "R9 model eng_dir");
      check(host_irq, drv_irq, "R6 model host_irq");
      check(reg_rdata, m_read(reg_addr, reg_size), "R5/R7 model reg_rdata");
    end
  end

  task automatic wr(input bit [2:0] a, input bit [1:0] s, input bit [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_size = s; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 0; reg_size = 0; reg_wdata = 0;
  endtask

  task automatic rd(input bit [2:0] a, input bit [1:0] s, input bit [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; reg_size = s;
    #1 check(reg_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    rd(0, 0, 0, "R10 cmd after reset");
    rd(2, 0, 0, "R10 status after reset");
    rd(4, 2, 0, "R10 base after reset");

    wr(4, 2, 32'h1234_5677);
    rd(4, 2, 32'h1234_5674, "R5 word write low bits zero");
    wr(5, 0, 32'h0000_00ab);
    rd(4, 2, 32'h1234_ab74, "R5 byte lane 1");
    wr(6, 1, 32'h0000_beef);
    rd(4, 2, 32'hbeef_ab74, "R5 half lanes 2-3");
    wr(4, 0, 32'h0000_00ff);
    rd(4, 2, 32'hbeef_abfc, "R5 byte lane 0 forced aligned");
    rd(7, 0, 32'h0000_00be, "R5 byte read at 7");
    rd(5, 1, 32'h0000_efab, "R5 half read at 5");
    wr(7, 2, 32'h1111_1199);
    rd(4, 2, 32'h99ef_abfc, "R5 lanes past byte 3 dropped");

    wr(0, 0, 32'h0000_00ff);
    check(eng_start, 1, "R2 start pulse");
    check(eng_ptr, 32'h99ef_abfc, "R2 pointer loaded");
    check(eng_dir, 1, "R9 direction set");
    rd(0, 0, 32'h9, "R1 only bits 0 and 3 kept");
    check(eng_start, 0, "R2 pulse is one cycle");
    rd(2, 0, 32'h1, "R2 active set");

    wr(4, 2, 32'h0000_0100);
    wr(0, 0, 32'h0000_0001);
    check(eng_start, 0, "R3 same start no pulse");
    check(eng_ptr, 32'h99ef_abfc, "R3 same start no reload");
    check(eng_dir, 0, "R9 direction cleared");

    wr(0, 0, 32'h0);
    rd(2, 0, 32'h1, "R4 active held after stop");
    idle(5);
    rd(2, 0, 32'h1, "R4 active held while in flight");
    @(negedge clk) eng_done = 1;
    @(negedge clk) eng_done = 0;
    rd(2, 0, 32'h0, "R4 done clears active");

    wr(0, 0, 32'h1);
    check(eng_start, 1, "R2 restart pulse");
    check(eng_ptr, 32'h100, "R2 reload new base");
    wr(0, 0, 32'h0);
    wr(4, 2, 32'h300);
    wr(0, 0, 32'h1);
    check(eng_start, 0, "R3 no pulse while active");
    check(eng_ptr, 32'h300, "R3 reload while active");

    @(negedge clk) eng_abort = 1;
    @(negedge clk) eng_abort = 0;
    rd(2, 0, 32'h2, "R8 abort sets error clears active");
    wr(2, 0, 32'h1);
    rd(2, 0, 32'h2, "R7 active bit not writable");
    wr(2, 0, 32'h2);
    rd(2, 0, 32'h0, "R7 error cleared by writing 1");

    @(negedge clk) drv_irq = 1;
    #1 check(host_irq, 1, "R6 host irq follows high");
    rd(2, 0, 32'h4, "R6 rise sets interrupt");
    wr(2, 0, 32'h4);
    rd(2, 0, 32'h0, "R7 interrupt cleared, R6 steady high no reset");
    @(negedge clk) drv_irq = 0;
    #1 check(host_irq, 0, "R6 host irq follows low");
    rd(2, 0, 32'h0, "R6 fall leaves status");
    @(negedge clk) drv_irq = 1;
    @(negedge clk) drv_irq = 0;
    rd(2, 0, 32'h4, "R6 bit kept after fall");

    wr(0, 0, 32'h0);
    wr(0, 0, 32'h9);
    rd(2, 0, 32'h5, "R2 active before reset");
    @(negedge clk) rst_n = 0;
    idle(2);
    @(negedge clk) rst_n = 1;
    rd(0, 0, 0, "R10 cmd cleared");
    rd(2, 0, 0, "R10 status cleared");
    rd(4, 2, 0, "R10 base cleared");
    check(eng_ptr, 0, "R10 pointer cleared");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule